// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block sits between a processor's word-wide load/store port and a slow memory that only moves whole 512-bit lines. It keeps sixteen lines of sixteen 32-bit words, one slot per memory line position. Loads and stores that find their line present finish inside the cache. A miss fetches the whole line from memory. If the slot's current occupant holds modified data, that line is first written back.

Stores that miss still fetch the line, then merge the stored word into it, so the cache always holds complete lines. Memory is written only when a modified line is displaced. Only one miss is handled at a time: the processor port stalls until the line has been installed. Write-backs get no reply from memory. Line reads return one reply, which carries the line.

Top module: `cache_dm_wb`

## Requirements
- R1: After reset every slot is invalid, `cpu_req_ready` is 1, and `cpu_resp_valid` and `mem_req_valid` are 0. The first access to any address therefore misses.
- R2: A load that hits returns the addressed word with `cpu_resp_valid` high in the cycle right after the request is accepted. It makes no memory request.
- R3: A store that hits replaces only the addressed word and marks the line modified. It makes no memory request, and a later load of that address returns the stored value.
- R4: A load miss on a slot that is invalid or unmodified makes exactly one line read. Its address is `addr[31:6]` and `mem_req_write` is 0. The response carries word `addr[5:2]` of the returned line and arrives in the cycle after the memory reply.
- R5: A store miss reads the line from memory and merges the store into it. The other fifteen words keep their memory values, and the installed line is marked modified.
- R6: A miss whose slot holds a modified line first issues a write. That write carries the old line's address (old tag, index), the line as the cache holds it, and all 64 bits of `mem_req_byteen` set. The line read for the new address follows it.
- R7: A miss whose slot holds an unmodified line issues no write.
- R8: From the acceptance of a missing request until its line is installed, `cpu_req_ready` is 0.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request's address and direction stay unchanged.
- R10: The address splits into index `addr[9:6]`, word offset `addr[5:2]` and tag `addr[31:10]`. Addresses with equal index and different tags displace each other. Lines with different indices stay present together.
- R11: Stores never raise `cpu_resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can take a request this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_resp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Line request present |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | 26 | Line address (byte address bits 31:6) |
| mem_req_byteen | output | 64 | Byte enables, all ones on write-back |
| mem_req_data | output | 512 | Write-back line |
| mem_resp_valid | input | 1 | Line read reply present |
| mem_resp_data | input | 512 | Line read reply data |

## Verification
A wrong valid, dirty or tag bit stays hidden until that slot is next used. A dropped dirty bit or a wrong tag shows up as stale load data after the next conflicting miss and refill. A stuck dirty bit shows up as an extra write-back on the next eviction from that slot. Word merge and offset errors show up in the returned word or in the written-back line. These faults can surface many requests after the cause, so the reference model tracks each slot and compares data and memory traffic on every transaction.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 16;
    localparam int NUM_LINES  = 16;

    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int BOFF_W     = $clog2(WORD_W / 8);
    localparam int WOFF_W     = $clog2(LINE_WORDS);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - WOFF_W - BOFF_W;
    localparam int LADDR_W    = ADDR_W - WOFF_W - BOFF_W;

    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WOFF_W-1:0]  off_t;
    typedef logic [LADDR_W-1:0] laddr_t;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WAIT  = 2'd3
    } cstate_e;

    typedef struct packed {
        logic  write;
        tag_t  tag;
        idx_t  idx;
        off_t  off;
        word_t wdata;
    } creq_t;

    function automatic creq_t split_req(logic wr, logic [ADDR_W-1:0] a, word_t d);
        creq_t r;
        r.write = wr;
        r.tag   = a[ADDR_W-1 -: TAG_W];
        r.idx   = a[BOFF_W+WOFF_W +: IDX_W];
        r.off   = a[BOFF_W +: WOFF_W];
        r.wdata = d;
        return r;
    endfunction

    function automatic word_t pick_word(line_t l, off_t o);
        return l[o*WORD_W +: WORD_W];
    endfunction

    function automatic line_t merge_word(line_t l, off_t o, word_t w);
        line_t r;
        r = l;
        r[o*WORD_W +: WORD_W] = w;
        return r;
    endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output logic rd_valid,
    output logic rd_dirty,
    output tag_t rd_tag,
    input  logic fill_we,
    input  idx_t fill_idx,
    input  tag_t fill_tag,
    input  logic fill_dirty,
    input  logic mark_we,
    input  idx_t mark_idx
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    tag_t                 tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_we) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= fill_dirty;
            end
            if (mark_we) begin
                dirty_q[mark_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store
    import cache_pkg::*;
(
    input  logic  clk,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  line_we,
    input  idx_t  line_idx,
    input  line_t line_wdata,
    input  logic  word_we,
    input  idx_t  word_idx,
    input  off_t  word_off,
    input  word_t word_wdata
);
    line_t lines_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (line_we) begin
            lines_q[line_idx] <= line_wdata;
        end else if (word_we) begin
            lines_q[word_idx] <= merge_word(lines_q[word_idx], word_off, word_wdata);
        end
    end

    assign rd_line = lines_q[rd_idx];
endmodule

// File: rtl/cache_dm_wb.sv
module cache_dm_wb
    import cache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req_valid,
    output logic                  cpu_req_ready,
    input  logic                  cpu_req_write,
    input  logic [ADDR_W-1:0]     cpu_req_addr,
    input  logic [WORD_W-1:0]     cpu_req_wdata,
    output logic                  cpu_resp_valid,
    output logic [WORD_W-1:0]     cpu_resp_data,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [LADDR_W-1:0]    mem_req_addr,
    output logic [LINE_BYTES-1:0] mem_req_byteen,
    output logic [LINE_W-1:0]     mem_req_data,
    input  logic                  mem_resp_valid,
    input  logic [LINE_W-1:0]     mem_resp_data
);
    cstate_e state_q;
    creq_t   pend_q;
    creq_t   cur;
    idx_t    look_idx;
    logic    slot_valid, slot_dirty, hit;
    tag_t    slot_tag;
    line_t   slot_line;
    logic    word_we, line_we;
    line_t   fill_line;

    assign cur      = split_req(cpu_req_write, cpu_req_addr, cpu_req_wdata);
    assign look_idx = (state_q == ST_READY) ? cur.idx : pend_q.idx;
    assign hit      = slot_valid && (slot_tag == cur.tag);

    assign cpu_req_ready = (state_q == ST_READY);
    assign word_we   = cpu_req_ready && cpu_req_valid && hit && cur.write;
    assign line_we   = (state_q == ST_WAIT) && mem_resp_valid;
    assign fill_line = pend_q.write ? merge_word(mem_resp_data, pend_q.off, pend_q.wdata)
                                    : mem_resp_data;

    cache_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (look_idx),
        .rd_valid   (slot_valid),
        .rd_dirty   (slot_dirty),
        .rd_tag     (slot_tag),
        .fill_we    (line_we),
        .fill_idx   (pend_q.idx),
        .fill_tag   (pend_q.tag),
        .fill_dirty (pend_q.write),
        .mark_we    (word_we),
        .mark_idx   (cur.idx)
    );

    cache_line_store u_lines (
        .clk        (clk),
        .rd_idx     (look_idx),
        .rd_line    (slot_line),
        .line_we    (line_we),
        .line_idx   (pend_q.idx),
        .line_wdata (fill_line),
        .word_we    (word_we),
        .word_idx   (cur.idx),
        .word_off   (cur.off),
        .word_wdata (cur.wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_READY;
            cpu_resp_valid <= 1'b0;
        end else begin
            cpu_resp_valid <= 1'b0;
            unique case (state_q)
                ST_READY: begin
                    if (cpu_req_valid) begin
                        if (hit) begin
                            if (!cur.write) begin
                                cpu_resp_valid <= 1'b1;
                            end
                        end else if (slot_valid && slot_dirty) begin
                            state_q <= ST_EVICT;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_EVICT: if (mem_req_ready) state_q <= ST_FILL;
                ST_FILL:  if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_resp_valid) begin
                        state_q <= ST_READY;
                        if (!pend_q.write) begin
                            cpu_resp_valid <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (cpu_req_ready && cpu_req_valid) begin
            pend_q <= cur;
            if (hit) begin
                cpu_resp_data <= pick_word(slot_line, cur.off);
            end
        end else if (line_we) begin
            cpu_resp_data <= pick_word(mem_resp_data, pend_q.off);
        end
    end

    assign mem_req_valid  = (state_q == ST_EVICT) || (state_q == ST_FILL);
    assign mem_req_write  = (state_q == ST_EVICT);
    assign mem_req_addr   = (state_q == ST_EVICT) ? laddr_t'({slot_tag, pend_q.idx})
                                                  : laddr_t'({pend_q.tag, pend_q.idx});
    assign mem_req_byteen = {LINE_BYTES{state_q == ST_EVICT}};
    assign mem_req_data   = slot_line;
endmodule

// File: rtl/cache_dm_wb_chk.sv
module cache_dm_wb_chk
    import cache_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cpu_req_valid,
    input logic                  cpu_req_ready,
    input logic                  cpu_req_write,
    input logic                  cpu_resp_valid,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_req_write,
    input logic [LADDR_W-1:0]    mem_req_addr,
    input logic [LINE_BYTES-1:0] mem_req_byteen
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!cpu_resp_valid && !mem_req_valid && cpu_req_ready)); // R1

    AST_MISS_STALLS_CPU: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !cpu_req_ready); // R8

    AST_WB_ALL_BYTES: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (&mem_req_byteen)); // R6

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write)); // R6

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R9

    AST_STORE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready && cpu_req_write) |=> !cpu_resp_valid); // R11

    AST_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> (cpu_req_ready && !mem_req_valid)); // R2
endmodule

bind cache_dm_wb cache_dm_wb_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_byteen (mem_req_byteen)
);

// File: tb/sim_cache_dm_wb.sv
`timescale 1ns/1ps
module sim_cache_dm_wb;
    import cache_pkg::*;

    localparam int MEM_LAT = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
    logic [31:0]   cpu_req_addr, cpu_req_wdata;
    logic          cpu_resp_valid;
    logic [31:0]   cpu_resp_data;
    logic          mem_req_valid, mem_req_ready, mem_req_write;
    logic [25:0]   mem_req_addr;
    logic [63:0]   mem_req_byteen;
    logic [511:0]  mem_req_data;
    logic          mem_resp_valid;
    logic [511:0]  mem_resp_data;

    always #2 clk = ~clk;

    cache_dm_wb u0 (.*);

    int total = 0;
    int bad   = 0;

    task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5EED1234;
    endfunction

    logic [31:0]  gold_w [logic [31:0]];
    logic [511:0] bmem   [logic [25:0]];

    function automatic logic [31:0] gold(logic [31:0] a);
        return gold_w.exists(a) ? gold_w[a] : init_word(a);
    endfunction

    function automatic logic [511:0] mem_line(logic [25:0] la);
        logic [511:0] l;
        if (bmem.exists(la)) return bmem[la];
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = init_word({la, 4'(w), 2'b00});
        return l;
    endfunction

    function automatic logic [511:0] gold_line(logic [25:0] la);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = gold({la, 4'(w), 2'b00});
        return l;
    endfunction

    // memory model
    int          n_rd = 0, n_wr = 0;
    logic [25:0] last_wb = '0;

    initial begin
        int           cd = -1;
        logic [25:0]  fill_la = '0;
        bit           s_acc = 0, s_wr = 0, s_hold = 0;
        logic [25:0]  s_la = '0;
        logic [63:0]  s_be = '0;
        logic [511:0] s_data = '0;
        mem_req_ready  = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_data  = '0;
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (s_hold) begin
                chk(mem_req_valid && mem_req_addr == s_la && mem_req_write == s_wr,
                    "R9", {mem_req_valid, mem_req_write, mem_req_addr},
                    {1'b1, s_wr, s_la});
            end
            if (s_acc) begin
                if (s_wr) begin
                    n_wr++;
                    last_wb = s_la;
                    chk(&s_be, "R6 byteen", s_be, {64{1'b1}});
                    chk(s_data == gold_line(s_la), "R6 wb data", s_data, gold_line(s_la));
                    bmem[s_la] = s_data;
                end else begin
                    n_rd++;
                    fill_la = s_la;
                    cd = MEM_LAT;
                end
            end
            if (cd == 0) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = mem_line(fill_la);
                cd = -1;
            end else if (cd > 0) begin
                cd--;
            end
            mem_req_ready = ($urandom % 4) != 0;
            s_acc  = !rst && mem_req_valid && mem_req_ready;
            s_hold = !rst && mem_req_valid && !mem_req_ready;
            s_wr   = mem_req_write;
            s_la   = mem_req_addr;
            s_be   = mem_req_byteen;
            s_data = mem_req_data;
        end
    end

    // reference slot model
    logic        mv [16];
    logic        md [16];
    logic [21:0] mt [16];

    task automatic do_req(bit wr, logic [31:0] a, logic [31:0] d);
        logic [3:0]  idx = a[9:6];
        logic [21:0] tg  = a[31:10];
        bit          hit = mv[idx] && mt[idx] == tg;
        bit          wb  = !hit && mv[idx] && md[idx];
        logic [25:0] old_la = {mt[idx], idx};
        int          rd0 = n_rd, wr0 = n_wr, lat = 1;
        bit          stall_ok = 1, resp_seen = 0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (wr) begin
            gold_w[a] = d;
            while (!cpu_req_ready) begin
                if (cpu_resp_valid) resp_seen = 1;
                @(negedge clk);
                lat++;
            end
            if (cpu_resp_valid) resp_seen = 1;
            chk(!resp_seen, "R11", resp_seen, 0);
            if (hit) chk(lat == 1, "R3 latency", lat, 1);
            else     chk(lat > 1, "R8 store miss stall", lat, 2);
        end else begin
            while (!cpu_resp_valid) begin
                if (cpu_req_ready) stall_ok = 0;
                @(negedge clk);
                lat++;
            end
            chk(cpu_resp_data == gold(a), hit ? "R2 data" : "R4 data", cpu_resp_data, gold(a));
            if (hit) chk(lat == 1, "R2 latency", lat, 1);
            else     chk(stall_ok && lat > 1, "R8 load miss stall", {stall_ok, 31'(lat)}, 1);
        end
        chk(n_rd - rd0 == (hit ? 0 : 1), hit ? "R3 no fill" : "R5 one fill", n_rd - rd0, hit ? 0 : 1);
        chk(n_wr - wr0 == (wb ? 1 : 0), wb ? "R6 writeback" : "R7 no writeback", n_wr - wr0, wb ? 1 : 0);
        if (wb) chk(last_wb == old_la, "R6 wb addr", last_wb, old_la);
        md[idx] = hit ? (md[idx] | wr) : wr;
        mv[idx] = 1'b1;
        mt[idx] = tg;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
        rst = 1'b1;
        cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
        cpu_req_addr = '0; cpu_req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_req_ready && !cpu_resp_valid && !mem_req_valid, "R1 reset",
            {cpu_req_ready, cpu_resp_valid, mem_req_valid}, 3'b100);

        // directed corners
        do_req(0, 32'h0000_0008, 0);            // R1 R4: cold load miss
        do_req(0, 32'h0000_003C, 0);            // R2: hit, last word
        do_req(1, 32'h0000_0008, 32'hCAFE_0001);// R3: store hit
        do_req(0, 32'h0000_0008, 0);            // R3: readback
        do_req(0, 32'h0000_0040, 0);            // R10: other index coexists
        do_req(0, 32'h0000_0004, 0);            // R10: still a hit
        do_req(0, 32'h0000_0400, 0);            // R6 R10: same index, evicts dirty
        do_req(0, 32'h0000_0008, 0);            // R6: stored value came back
        do_req(0, 32'h0000_0400, 0);            // R7: clean eviction
        do_req(1, 32'h0000_0844, 32'h1234_ABCD);// R5: store miss allocate
        do_req(0, 32'h0000_0840, 0);            // R5: neighbour keeps memory value
        do_req(0, 32'h0000_0844, 0);            // R5: merged word
        do_req(1, 32'hFFFF_FC3C, 32'h0BAD_F00D);// R10: top tag, index 0
        do_req(0, 32'h0000_0800, 0);            // R6: evicts dirty top-tag line
        do_req(0, 32'hFFFF_FC3C, 0);            // R6: top line restored

        // constrained random
        for (int n = 0; n < 1500; n++) begin
            int          ts  = $urandom % 5;
            logic [21:0] tg  = (ts == 4) ? (22'h3FFFF0 | 22'($urandom % 4)) : 22'(ts);
            logic [3:0]  idx = 4'($urandom % 8);
            logic [3:0]  off = 4'($urandom);
            do_req(($urandom % 2) == 1, {tg, idx, off, 2'b00}, $urandom);
        end

        summary();
        $finish;
    end
endmodule